// File: doc/BRIEF.md
# NAND Block Erase Sequencer

This controller sits on the host side of a NAND flash bus and carries out one block erase per request. The host offers a block number through a valid/ready handshake. The sequencer then writes the erase setup command, two address bytes and the erase confirm command. It writes the status-read command once and reads the status byte again and again until the device reports ready. Last, it writes the read command so that the device leaves status mode, and it raises a one-cycle done pulse with the outcome.

Completion is taken from the status byte and never from the ready/busy pin. That pin may be wired to several devices, so the sequencer does not look at it. Every strobe phase (setup, active pulse, hold) lasts a number of system clock cycles set by a parameter. A poll limit ends a wait that never finishes.

Top module: `nand_erase_seq`

## Requirements
- R1: While reset is held, `req_ready` is 1, `we_n` and `re_n` are 1, `cle`, `ale`, `dq_oe` and `done` are 0.
- R2: `req_ready` is 1 only when idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. While a sequence runs, `req_ready` is 0 and `req_valid` has no effect.
- R3: Each bus write cycle holds `we_n` high for SETUP_CYC cycles, then low for exactly PULSE_CYC cycles, then high for HOLD_CYC cycles. `cle`/`ale` and `dq_out` are held over all three phases and `dq_oe` is 1.
- R4: The erase writes, in order: command 8'h60 (`cle`=1), two address bytes (`ale`=1), then command 8'hD0 (`cle`=1).
- R5: The first address byte is {block[2:0], 5'b00000} and the second is block[10:3]. The low five bits of the first byte are the ignored row bits and are driven as zero.
- R6: After 8'hD0, command 8'h70 is written exactly once. Status read cycles follow, with `re_n` low for PULSE_CYC cycles, `dq_oe` 0, and no command written between reads.
- R7: The status byte is sampled on the last cycle of each `re_n` low pulse. Bit 6 = 1 means the erase has ended, and `err_fail` then takes bit 0.
- R8: If a sampled status has bit 7 = 0, the poll ends with `err_wp` = 1 and `err_fail` = 0. This check takes priority over bit 6.
- R9: If MAX_POLLS reads in a row show bit 6 = 0, polling stops with `err_timeout` = 1. If the final allowed read shows bit 6 = 1, the erase completes with no timeout.
- R10: After polling ends, whatever the outcome, command 8'h00 is written once, before `done`.
- R11: `done` is a one-cycle pulse after the 8'h00 cycle. `err_fail`, `err_wp`, `err_timeout` and `status` (the last sampled byte) hold until the next request is taken. At most one error flag is 1.
- R12: `cle` and `ale` are never 1 together, and `we_n` and `re_n` are never 0 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Erase request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_block | input | 11 | Block number to erase |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| err_fail | output | 1 | Device reported a failed erase |
| err_wp | output | 1 | Device reported write protection |
| err_timeout | output | 1 | Poll limit reached without ready |
| status | output | 8 | Last status byte sampled |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| dq_out | output | 8 | Data driven onto the flash bus |
| dq_oe | output | 1 | Output enable for `dq_out` |
| dq_in | input | 8 | Data read from the flash bus |

## Verification
The poll limit and the ready report can fall on the same status read. The bench's flash model keeps the status busy for exactly MAX_POLLS-1 reads and shows ready on the last read allowed. This run passes only if the erase ends clean with `err_timeout` at 0 and exactly MAX_POLLS reads. A separate run keeps the device busy past the limit, and there the timeout must win after the same number of reads.

// File: rtl/nand_erase_seq.sv
module nand_erase_seq #(
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 3,
  parameter int HOLD_CYC  = 2,
  parameter int MAX_POLLS = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [10:0] req_block,
  output logic        done,
  output logic        err_fail,
  output logic        err_wp,
  output logic        err_timeout,
  output logic [7:0]  status,
  output logic        cle,
  output logic        ale,
  output logic        we_n,
  output logic        re_n,
  output logic [7:0]  dq_out,
  output logic        dq_oe,
  input  logic [7:0]  dq_in
);
  localparam int TMAX = (SETUP_CYC > PULSE_CYC) ?
                        ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                        ((PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC);
  localparam int TW = $clog2(TMAX + 1);
  localparam int CW = $clog2(MAX_POLLS);

  typedef enum logic [3:0] {S_IDLE, S_C60, S_A1, S_A2, S_CD0, S_C70, S_RD, S_C00, S_FIN} st_t;
  typedef enum logic [1:0] {P_SU, P_PW, P_HD} ph_t;

  st_t         st;
  ph_t         ph;
  logic [TW-1:0] cnt;
  logic [CW-1:0] polls;
  logic [10:0] blk;

  logic cmd_op, wr_op;
  assign cmd_op = st inside {S_C60, S_CD0, S_C70, S_C00};
  assign wr_op  = cmd_op || st inside {S_A1, S_A2};

  assign req_ready = st == S_IDLE;
  assign done      = st == S_FIN;
  assign cle       = cmd_op;
  assign ale       = st inside {S_A1, S_A2};
  assign dq_oe     = wr_op;
  assign we_n      = !(wr_op && ph == P_PW);
  assign re_n      = !(st == S_RD && ph == P_PW);

  always_comb begin
    case (st)
      S_C60:   dq_out = 8'h60;
      S_A1:    dq_out = {blk[2:0], 5'b00000};
      S_A2:    dq_out = blk[10:3];
      S_CD0:   dq_out = 8'hD0;
      S_C70:   dq_out = 8'h70;
      default: dq_out = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ph <= P_SU;
      cnt <= '0;
      polls <= '0;
      blk <= '0;
      status <= '0;
      err_fail <= 1'b0;
      err_wp <= 1'b0;
      err_timeout <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          blk <= req_block;
          status <= '0;
          err_fail <= 1'b0;
          err_wp <= 1'b0;
          err_timeout <= 1'b0;
          polls <= '0;
          st <= S_C60;
          ph <= P_SU;
          cnt <= TW'(SETUP_CYC - 1);
        end
        S_FIN: st <= S_IDLE;
        default: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            case (ph)
              P_SU: begin
                ph <= P_PW;
                cnt <= TW'(PULSE_CYC - 1);
              end
              P_PW: begin
                ph <= P_HD;
                cnt <= TW'(HOLD_CYC - 1);
                if (st == S_RD) status <= dq_in;
              end
              default: begin
                ph <= P_SU;
                cnt <= TW'(SETUP_CYC - 1);
                case (st)
                  S_C60: st <= S_A1;
                  S_A1:  st <= S_A2;
                  S_A2:  st <= S_CD0;
                  S_CD0: st <= S_C70;
                  S_C70: st <= S_RD;
                  S_C00: st <= S_FIN;
                  default: begin
                    if (!status[7]) begin
                      err_wp <= 1'b1;
                      st <= S_C00;
                    end else if (status[6]) begin
                      err_fail <= status[0];
                      st <= S_C00;
                    end else if (polls == CW'(MAX_POLLS - 1)) begin
                      err_timeout <= 1'b1;
                      st <= S_C00;
                    end else polls <= polls + 1'b1;
                  end
                endcase
              end
            endcase
          end
        end
      endcase
    end
  end

  // R12
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale));
  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!we_n && !re_n));
  // R6
  read_bus_free_chk: assert property (@(posedge clk) disable iff (!rst_n) !re_n |-> !dq_oe);
  // R2
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R11
  one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_fail, err_wp, err_timeout}));
  // R11
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable({err_fail, err_wp, err_timeout, status}));
  // R9
  ready_beats_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_RD && ph == P_HD && cnt == '0 && status[7] && status[6] |=> !err_timeout);
endmodule

// File: tb/sim_nand_erase_seq.sv
module sim_nand_erase_seq;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 2;
  localparam int NPOLL = 8;
  localparam int NV = 5;

  localparam int V_BLK  [NV] = '{11'h000, 11'h7FF, 11'h2A5, 11'h123, 11'h555};
  localparam int V_BUSY [NV] = '{0, 3, 2, 20, 7};
  localparam int V_FIN  [NV] = '{8'hC0, 8'hC1, 8'h40, 8'hC0, 8'hC0};
  localparam int V_RDS  [NV] = '{1, 4, 3, 8, 8};
  localparam int V_FAIL [NV] = '{0, 1, 0, 0, 0};
  localparam int V_WP   [NV] = '{0, 0, 1, 0, 0};
  localparam int V_TO   [NV] = '{0, 0, 0, 1, 0};
  localparam int V_ST   [NV] = '{8'hC0, 8'hC1, 8'h40, 8'h80, 8'hC0};

  logic clk = 0, rst_n = 0, req_valid = 0, clr = 0;
  logic [10:0] req_block = '0;
  logic req_ready, done, err_fail, err_wp, err_timeout, cle, ale, we_n, re_n, dq_oe;
  logic [7:0] status, dq_out, dq_in;
  int total = 0, bad = 0;
  int busy = 0, fin_st = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_erase_seq #(.SETUP_CYC(1), .PULSE_CYC(PW), .HOLD_CYC(1), .MAX_POLLS(NPOLL)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_block(req_block), .done(done), .err_fail(err_fail), .err_wp(err_wp),
    .err_timeout(err_timeout), .status(status), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in));

  logic [9:0] lg [16];
  int idx, rd_done, wl, pw_bad;
  logic we_q, re_q;
  assign dq_in = (rd_done < busy) ? 8'h80 : 8'(fin_st);

  always @(posedge clk) begin
    we_q <= we_n;
    re_q <= re_n;
    if (clr) begin
      idx <= 0; rd_done <= 0; wl <= 0; pw_bad <= 0;
    end else begin
      if (!we_n) wl <= wl + 1;
      if (we_n && !we_q) begin
        if (idx < 16) lg[idx] <= {cle, ale, dq_out};
        idx <= idx + 1;
        if (wl != PW) pw_bad <= 1;
        wl <= 0;
      end
      if (re_n && !re_q) rd_done <= rd_done + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp_v);
    end
  endtask

  task automatic run_vec(input int i, input bit hammer);
    int ex [6];
    busy = V_BUSY[i];
    fin_st = V_FIN[i];
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    req_valid = 1;
    req_block = 11'(V_BLK[i]);
    @(negedge clk);
    chk(!req_ready, "R2 ready low after accept", req_ready, 0);
    if (hammer) req_block = 11'h001; else req_valid = 0;
    for (int k = 0; k < 3000 && !done; k++) @(negedge clk);
    req_valid = 0;
    chk(done, "R11 done seen", done, 1);
    ex[0] = 10'h260;
    ex[1] = 10'h100 | {V_BLK[i][2:0], 5'b0};
    ex[2] = 10'h100 | V_BLK[i][10:3];
    ex[3] = 10'h2D0;
    ex[4] = 10'h270;
    ex[5] = 10'h200;
    chk(idx == 6, "R2 R6 R10 write count", idx, 6);
    chk(lg[0] == 10'(ex[0]) && lg[3] == 10'(ex[3]), "R4 setup/confirm cmds", {lg[0], lg[3]}, {ex[0], ex[3]});
    chk(lg[1] == 10'(ex[1]), "R5 address byte 1", lg[1], ex[1]);
    chk(lg[2] == 10'(ex[2]), "R5 address byte 2", lg[2], ex[2]);
    chk(lg[4] == 10'(ex[4]), "R6 status cmd", lg[4], ex[4]);
    chk(lg[5] == 10'(ex[5]), "R10 read cmd", lg[5], ex[5]);
    chk(pw_bad == 0, "R3 write pulse width", pw_bad, 0);
    chk(rd_done == V_RDS[i], "R6 R9 read count", rd_done, V_RDS[i]);
    chk(err_fail == V_FAIL[i][0], "R7 fail flag", err_fail, V_FAIL[i]);
    chk(err_wp == V_WP[i][0], "R8 protect flag", err_wp, V_WP[i]);
    chk(err_timeout == V_TO[i][0], "R9 timeout flag", err_timeout, V_TO[i]);
    chk(status == 8'(V_ST[i]), "R7 status byte", status, V_ST[i]);
    @(negedge clk);
    chk(!done, "R11 done one cycle", done, 0);
    chk(req_ready, "R2 ready back", req_ready, 1);
    repeat (3) @(negedge clk);
    chk(err_fail == V_FAIL[i][0] && err_wp == V_WP[i][0] && err_timeout == V_TO[i][0],
        "R11 flags held", {err_fail, err_wp, err_timeout}, {V_FAIL[i][0], V_WP[i][0], V_TO[i][0]});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready, "R1 ready in reset", req_ready, 1);
    chk(we_n && re_n, "R1 strobes idle", {we_n, re_n}, 2'b11);
    chk(!cle && !ale, "R1 latches low", {cle, ale}, 0);
    chk(!dq_oe, "R1 bus released", dq_oe, 0);
    chk(!done, "R1 done low", done, 0);
    rst_n = 1;
    for (int i = 0; i < NV; i++) run_vec(i, i == 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule